// File: doc/BRIEF.md
# Coin Lockout and Counter Control Register

This block sits on the main processor's write bus and turns writes into a small address window into four control levels: two coin-lockout solenoid controls and two coin-counter drive outputs. The word offset of a write, measured from the window base, is shifted right by three to form a group number. Groups 0 and 1 address the lockouts and groups 2 and 3 address the counters. The lowest bit of the group number picks the channel.

Each output is a flip-flop that takes one bit of the write data. Lockouts sample data bit 10 and counters sample data bit 8. A write takes effect only when the upper byte lane is strobed. Software pulses a counter by writing it high and then low. All outputs come up low after reset, which means the lockouts are released and the counters are idle.

Top module: `coin_ctrl_reg`

## Requirements
- R1: A clock edge with `rst_n` low clears `lock_o` and `count_o` to all zeros. This state is visible from the next cycle.
- R2: A write with `wr_be[1]` low changes no output, whatever the address and data.
- R3: Writes to byte addresses below 0x84000A or above 0x84003B change no output. Inside the window, word offset = (address − 0x84000A) >> 1, so address bit 0 has no influence on decoding.
- R4: A write whose group (word offset >> 3) is 0 or 1 loads data bit 10 into `lock_o[group bit 0]` one cycle later.
- R5: A write whose group is 2 or 3 loads data bit 8 into `count_o[group bit 0]` one cycle later.
- R6: Lockout writes ignore data bit 8 and counter writes ignore data bit 10, together with all other data bits.
- R7: An output keeps its value until a write addresses it. A write changes only the single output it addresses.
- R8: With `wr_en` low no output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 24 | Byte address of the write |
| wr_data | input | 16 | Write data word |
| wr_be | input | 2 | Byte-lane enables; bit 1 is the upper lane |
| lock_o | output | 2 | Coin-lockout controls, channel 0 and 1 |
| count_o | output | 2 | Coin-counter drives, channel 0 and 1 |

## Verification
The assertions check several rules on every cycle: outputs are cleared after reset, and writes that are disabled, lack the upper lane or fall outside the window leave all outputs unchanged. They also check that a lockout write takes data bit 10 into the addressed channel and leaves the counters untouched. Other properties can only be shown by the bench's write sequence. These are that the group boundary falls at every eighth word, that the odd byte address at the window's end still reaches the second counter, and that the ignored data bit really has no effect. The sequence also shows that values hold across idle time and survive until a reset arrives in the middle of operation.

// File: rtl/coin_pkg.sv
// Shared constants for the coin control register.
// Assumes two channels per function and two functions (lockout, counter).
package coin_pkg;
    localparam int COIN_CH    = 2;              // channels per function
    localparam int COIN_FN    = 2;              // lockout, counter
    localparam int COIN_OUTS  = COIN_CH * COIN_FN;
    localparam int GRP_SHIFT  = 3;              // words per group = 2**GRP_SHIFT

    typedef enum logic [0:0] {
        FN_LOCK  = 1'b0,
        FN_COUNT = 1'b1
    } coin_fn_e;

    // Function served by output slot i (slot = group number)
    function automatic coin_fn_e slot_fn(input int i);
        return (i / COIN_CH == 0) ? FN_LOCK : FN_COUNT;
    endfunction
endpackage

// File: rtl/coin_win_decode.sv
// Window and group decoder.
// Turns a byte address into one select line per output slot.
// Assumes BASE is even. The group is the word offset from BASE shifted
// right by GRP_SHIFT. Groups at or above NSEL select nothing.
module coin_win_decode #(
    parameter int              ADDR_W = 24,
    parameter logic [ADDR_W-1:0] BASE = 24'h84000A,
    parameter logic [ADDR_W-1:0] LAST = 24'h84003B,
    parameter int              NSEL   = 4
) (
    input  logic              hit_en,
    input  logic [ADDR_W-1:0] addr,
    output logic [NSEL-1:0]   sel
);
    localparam int GW = ADDR_W - 1 - coin_pkg::GRP_SHIFT;

    logic              in_win;
    logic [ADDR_W-1:0] byte_off;
    logic [GW-1:0]     grp;

    // Range check and offset arithmetic
    always_comb begin
        in_win   = (addr >= BASE) && (addr <= LAST);
        byte_off = addr - BASE;
        grp      = byte_off[ADDR_W-1:1+coin_pkg::GRP_SHIFT];
    end

    // One select line per group that owns an output
    for (genvar i = 0; i < NSEL; i++) begin : g_sel
        assign sel[i] = hit_en && in_win && (grp == GW'(i));
    end
endmodule

// File: rtl/coin_out_bit.sv
// One output flop: loads d when we is high, otherwise holds.
// Assumes a synchronous active-low reset to zero.
module coin_out_bit (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic d,
    output logic q
);
    // Hold-or-load register with synchronous clear
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= 1'b0;
        else if (we) q <= d;
    end
endmodule

// File: rtl/coin_ctrl_reg.sv
// Coin lockout and counter control register.
// Decodes upper-lane writes in a byte window into four output flops.
// Slots 0..COIN_CH-1 are lockouts and take data bit LOCK_BIT. The
// following slots are counters and take data bit CNT_BIT.
module coin_ctrl_reg #(
    parameter int              ADDR_W   = 24,
    parameter int              DATA_W   = 16,
    parameter logic [ADDR_W-1:0] BASE   = 24'h84000A,
    parameter logic [ADDR_W-1:0] LAST   = 24'h84003B,
    parameter int              LOCK_BIT = 10,
    parameter int              CNT_BIT  = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [1:0]               wr_be,
    output logic [coin_pkg::COIN_CH-1:0] lock_o,
    output logic [coin_pkg::COIN_CH-1:0] count_o
);
    import coin_pkg::*;

    localparam int NOUT = COIN_OUTS;

    logic            hit;
    logic [NOUT-1:0] sel;
    logic [NOUT-1:0] out_q;

    // Only upper-lane writes can reach the outputs
    assign hit = wr_en && wr_be[1];

    coin_win_decode #(
        .ADDR_W (ADDR_W),
        .BASE   (BASE),
        .LAST   (LAST),
        .NSEL   (NOUT)
    ) u_dec (
        .hit_en (hit),
        .addr   (wr_addr),
        .sel    (sel)
    );

    // One flop per slot, data bit chosen by the slot's function
    for (genvar i = 0; i < NOUT; i++) begin : g_out
        localparam int SRC = (slot_fn(i) == FN_LOCK) ? LOCK_BIT : CNT_BIT;
        coin_out_bit u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (sel[i]),
            .d     (wr_data[SRC]),
            .q     (out_q[i])
        );
    end

    assign lock_o  = out_q[COIN_CH-1:0];
    assign count_o = out_q[NOUT-1:COIN_CH];
endmodule

// File: rtl/coin_ctrl_reg_chk.sv
// Property checker for coin_ctrl_reg, attached by bind below.
// Assumes the default two-channel arrangement.
module coin_ctrl_reg_chk #(
    parameter int              ADDR_W   = 24,
    parameter int              DATA_W   = 16,
    parameter logic [ADDR_W-1:0] BASE   = 24'h84000A,
    parameter logic [ADDR_W-1:0] LAST   = 24'h84003B,
    parameter int              LOCK_BIT = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic [1:0]        wr_be,
    input logic [1:0]        lock_o,
    input logic [1:0]        count_o
);
    logic              was_rst;
    logic [ADDR_W-1:0] off;
    logic              lock_wr0;
    logic              lock_wr;
    logic              outside;

    // Requirement-level view of the write: window offset and lockout hits
    always_comb begin
        off      = wr_addr - BASE;
        outside  = (wr_addr < BASE) || (wr_addr > LAST);
        lock_wr  = wr_en && wr_be[1] && !outside && (off[ADDR_W-1:5] == '0);
        lock_wr0 = lock_wr && (off[4] == 1'b0);
    end

    // Remember that reset was asserted at the previous edge
    always_ff @(posedge clk) was_rst <= !rst_n;

    // R1
    always_ff @(posedge clk) begin
        if (was_rst) reset_clear_chk: assert ({lock_o, count_o} == 4'b0);
    end

    // R2
    no_upper_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[1]) |=> $stable({lock_o, count_o}));

    // R3
    outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && outside) |=> $stable({lock_o, count_o}));

    // R8
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable({lock_o, count_o}));

    // R4
    lock0_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr0 |=> (lock_o[0] == $past(wr_data[LOCK_BIT])));

    // R7
    lock_spares_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |=> $stable(count_o));
endmodule

bind coin_ctrl_reg coin_ctrl_reg_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BASE     (BASE),
    .LAST     (LAST),
    .LOCK_BIT (LOCK_BIT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .lock_o  (lock_o),
    .count_o (count_o)
);

// File: tb/coin_ctrl_reg_test.sv
// Bench for coin_ctrl_reg: vector table walk, then directed reset and hold tests.
module coin_ctrl_reg_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [23:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic [1:0]  lock_o;
    logic [1:0]  count_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    coin_ctrl_reg uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be),
        .lock_o  (lock_o),
        .count_o (count_o)
    );

    // Outputs packed as {count1, count0, lock1, lock0}
    typedef struct packed {
        logic [23:0] a;
        logic [15:0] d;
        logic [1:0]  be;
        logic        we;
        logic [3:0]  exp;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{24'h84000A, 16'h0400, 2'b11, 1'b1, 4'b0001, 4'd4}, // R4 group 0 -> lock0
        '{24'h84001A, 16'h0400, 2'b11, 1'b1, 4'b0011, 4'd4}, // R4 group 1 -> lock1
        '{24'h84002A, 16'h0100, 2'b11, 1'b1, 4'b0111, 4'd5}, // R5 group 2 -> count0
        '{24'h84003A, 16'h0100, 2'b11, 1'b1, 4'b1111, 4'd5}, // R5 group 3 -> count1
        '{24'h840018, 16'h0000, 2'b11, 1'b1, 4'b1110, 4'd4}, // R4 last word of group 0
        '{24'h840028, 16'h0100, 2'b11, 1'b1, 4'b1100, 4'd6}, // R6 bit 8 ignored by lockout
        '{24'h840038, 16'h0400, 2'b11, 1'b1, 4'b1000, 4'd6}, // R6 bit 10 ignored by counter
        '{24'h84003B, 16'h0000, 2'b11, 1'b1, 4'b0000, 4'd3}, // R3 odd byte at window end
        '{24'h840020, 16'h0400, 2'b01, 1'b1, 4'b0000, 4'd2}, // R2 lower lane only
        '{24'h840020, 16'h0400, 2'b10, 1'b1, 4'b0010, 4'd2}, // R2 upper lane alone suffices
        '{24'h84003C, 16'hFFFF, 2'b11, 1'b1, 4'b0010, 4'd3}, // R3 just above window
        '{24'h840008, 16'hFFFF, 2'b11, 1'b1, 4'b0010, 4'd3}, // R3 just below window
        '{24'h840030, 16'hFFFF, 2'b11, 1'b0, 4'b0010, 4'd8}, // R8 strobe low
        '{24'h840030, 16'hFBFF, 2'b11, 1'b1, 4'b0110, 4'd7}  // R7 only count0 changes
    };

    // Compare outputs against an expected value
    task automatic check(input logic [3:0] exp, input int req, input string what);
        logic [3:0] act;
        act = {count_o, lock_o};
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // Drive one bus cycle at a falling edge; outputs settle after the next rising edge
    task automatic bus_write(input logic [23:0] a, input logic [15:0] d,
                             input logic [1:0] be, input logic we);
        @(negedge clk);
        wr_addr = a; wr_data = d; wr_be = be; wr_en = we;
        @(negedge clk);
        wr_en = 1'b0; wr_be = 2'b00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(4'b0000, 1, "R1 state after reset");
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            bus_write(VECS[i].a, VECS[i].d, VECS[i].be, VECS[i].we);
            check(VECS[i].exp, int'(VECS[i].req), $sformatf("vector %0d", i));
        end

        // R7: values hold across idle cycles
        repeat (10) @(negedge clk);
        check(4'b0110, 7, "R7 hold after idle");

        // R5: set count1, then clear it again as a pulse
        bus_write(24'h84003B, 16'h0100, 2'b10, 1'b1);
        check(4'b1110, 5, "R5 count1 high");
        bus_write(24'h84003A, 16'h0000, 2'b10, 1'b1);
        check(4'b0110, 5, "R5 count1 low");

        // R1: reset in mid operation clears everything
        bus_write(24'h84000A, 16'h0400, 2'b11, 1'b1);
        check(4'b0111, 4, "R4 lock0 before reset");
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check(4'b0000, 1, "R1 mid-run reset");
        rst_n = 1'b1;

        // R8: write attempt with strobe low after reset
        bus_write(24'h84001A, 16'hFFFF, 2'b11, 1'b0);
        check(4'b0000, 8, "R8 strobe low after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule